// File: doc/BRIEF.md
# Sign-Magnitude Adder/Subtractor

A purely combinational unit that adds or subtracts two words held in sign-magnitude form. The top bit of each word is the sign (0 positive, 1 negative) and the lower W-1 bits are an unsigned magnitude. The result comes back in the same form, together with an overflow flag and a zero flag.

Subtraction is handled by flipping the sign of the second operand. The add rule then runs on the two signs. If the signs match, the magnitudes are summed and the common sign is kept. If they differ, the smaller magnitude is taken from the larger one, and the result takes the sign of the operand whose magnitude was larger. Both zero encodings are accepted on the inputs, and a zero result is always produced as positive zero.

Top module: `sm_addsub`

## Requirements
- R1: With equal effective signs and a magnitude sum below 2^(W-1), the result magnitude is the sum of the magnitudes, the result sign is the common sign, and ovf_o is 0.
- R2: With differing effective signs, the result magnitude is the larger magnitude minus the smaller one, the result sign is the sign of the operand with the larger magnitude, and ovf_o is 0.
- R3: With equal effective signs and a magnitude sum of 2^(W-1) or more, ovf_o is 1 and the result magnitude is the sum modulo 2^(W-1), carrying the common sign (or 0 if that wrapped magnitude is zero).
- R4: When sub_i is 1, the sign bit of b_i is inverted before the rules of R1 to R3 are applied. When sub_i is 0, b_i is used as given.
- R5: Differing effective signs with equal magnitudes give the all-zero word (positive zero).
- R6: Any result whose magnitude is zero has a sign bit of 0, including negative zero plus negative zero.
- R7: zero_o is 1 exactly when the result magnitude is zero.
- R8: An operand equal to negative zero (sign 1, magnitude 0) behaves as zero: adding it to x returns x, with a sign of 0 if x is itself a zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand, sign-magnitude |
| b_i | input | W | Second operand, sign-magnitude |
| sub_i | input | 1 | 0 = a_i + b_i, 1 = a_i - b_i |
| res_o | output | W | Result, sign-magnitude |
| ovf_o | output | 1 | Magnitude sum did not fit in W-1 bits |
| zero_o | output | 1 | Result is zero |

## Verification
The hardest corner to reach is a zero result that arises with a sign of 1 on its way out. This happens when negative zero is added to negative zero, when an overflow wraps the sum to exactly 2^(W-1), or when a subtraction cancels two equal magnitudes. With W=6, the bench sweeps every pair of operands under both operations. Every negative-zero encoding, every cancelling pair and every wrap to zero is therefore applied. The expected results come from plain signed integer arithmetic.

// File: rtl/sm_addsub.sv
module sm_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o,
  output logic         zero_o
);
  localparam int M = W - 1;

  logic         sa, sb, sr, ovf;
  logic [M-1:0] ma, mb, mag, mbig;
  logic [M:0]   msum;

  always_comb begin
    sa   = a_i[W-1];
    sb   = b_i[W-1] ^ sub_i;
    ma   = a_i[M-1:0];
    mb   = b_i[M-1:0];
    msum = {1'b0, ma} + {1'b0, mb};
    mbig = (ma >= mb) ? ma : mb;
    ovf  = 1'b0;
    if (sa == sb) begin
      mag = msum[M-1:0];
      ovf = msum[M];
      sr  = sa;
    end else if (ma >= mb) begin
      mag = ma - mb;
      sr  = sa;
    end else begin
      mag = mb - ma;
      sr  = sb;
    end
    if (mag == '0) sr = 1'b0;

    a_r1_sum_grows: assert ((sa != sb) || ovf || (mag >= ma && mag >= mb))
      else $error("R1 sum smaller than an operand");
    a_r2_mixed_bounded: assert ((sa == sb) || (!ovf && mag <= mbig))
      else $error("R2 mixed-sign result out of bound");
    a_r3_wrap_shrinks: assert (!ovf || (mag < ma && mag < mb))
      else $error("R3 overflow without wrap");
    a_r5_cancel: assert ((sa == sb) || (ma != mb) || (mag == '0 && !sr))
      else $error("R5 cancel not positive zero");
  end

  assign res_o  = {sr, mag};
  assign ovf_o  = ovf;
  assign zero_o = (mag == '0);
endmodule

// File: tb/tb_sm_addsub.sv
module tb_sm_addsub;
  localparam int W = 6;
  localparam int M = W - 1;
  localparam int LIM = 1 << M;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a, b, res;
  logic sub, ovf, zero;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sm_addsub #(.W(W)) dut (.a_i(a), .b_i(b), .sub_i(sub), .res_o(res), .ovf_o(ovf), .zero_o(zero));

  task automatic check(input string tag, input logic [W+1:0] got, input logic [W+1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s a=%b b=%b sub=%0d got={res,ovf,zero}=%b exp=%b", tag, a, b, sub, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] ia, input logic [W-1:0] ib, input logic op);
    @(negedge clk);
    a = ia; b = ib; sub = op;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [W+1:0] model(input logic [W-1:0] ia, input logic [W-1:0] ib, input logic op);
    int va, vb, s, am, m;
    logic sg, o;
    va = ia[W-1] ? -int'(ia[M-1:0]) : int'(ia[M-1:0]);
    vb = (ib[W-1] ^ op) ? -int'(ib[M-1:0]) : int'(ib[M-1:0]);
    s  = va + vb;
    am = (s < 0) ? -s : s;
    o  = (am >= LIM);
    m  = am % LIM;
    sg = (m != 0) && (s < 0);
    return {sg, m[M-1:0], o, (m == 0)};
  endfunction

  function automatic string tag_of(input logic [W-1:0] ia, input logic [W-1:0] ib, input logic op);
    logic mixed;
    mixed = ia[W-1] != (ib[W-1] ^ op);
    if (ia[M-1:0] == 0 && ia[W-1]) return "R8";
    if (mixed && ia[M-1:0] == ib[M-1:0]) return "R5";
    if (!mixed && (int'(ia[M-1:0]) + int'(ib[M-1:0]) >= LIM)) return "R3";
    if (op) return mixed ? "R4/R2" : "R4/R1";
    return mixed ? "R2" : "R1";
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; sub = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    check("reset R7", {res, ovf, zero}, {{W{1'b0}}, 1'b0, 1'b1});

    apply(6'b100000, 6'b100000, 1'b0);
    check("R6 -0 + -0", {res, ovf, zero}, {6'b000000, 1'b0, 1'b1});
    apply(6'b100000, 6'b000011, 1'b0);
    check("R8 -0 + 3", {res, ovf, zero}, {6'b000011, 1'b0, 1'b0});
    apply(6'b000011, 6'b100010, 1'b1);
    check("R4 3 - (-2)", {res, ovf, zero}, {6'b000101, 1'b0, 1'b0});
    apply(6'b110000, 6'b110000, 1'b0);
    check("R3 R6 -16 + -16 wraps", {res, ovf, zero}, {6'b000000, 1'b1, 1'b1});
    apply(6'b000111, 6'b000111, 1'b1);
    check("R5 7 - 7", {res, ovf, zero}, {6'b000000, 1'b0, 1'b1});
    apply(6'b000010, 6'b100111, 1'b0);
    check("R2 2 + -7", {res, ovf, zero}, {6'b100101, 1'b0, 1'b0});

    for (int op = 0; op < 2; op++)
      for (int ia = 0; ia < (1 << W); ia++)
        for (int ib = 0; ib < (1 << W); ib++) begin
          apply(ia[W-1:0], ib[W-1:0], op[0]);
          check(tag_of(ia[W-1:0], ib[W-1:0], op[0]), {res, ovf, zero},
                model(ia[W-1:0], ib[W-1:0], op[0]));
          if (zero !== 1'b1 && res[M-1:0] == '0) check("R7", {res, ovf, zero}, {res, ovf, 1'b1});
        end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule